// File: doc/BRIEF.md
# Streaming Block Zero Detector

This block sits on the fill path of a zero-tracking tag cache. A large entry block arrives from memory as a stream of fixed-width beats, one per handshake. The block tests every element of every beat for an all-zero value and builds a zero map that covers the whole entry block, not only the piece a demand request asked for. Elements are bytes or words, and a parameter picks which.

The first beat of a block carries a start marker, the entry's tag and the index of the sub-block the demand request needed. An entry block spans several sub-blocks of the lower-level cache. When the final beat has been accepted, the block presents one insertion record. The record holds the tag, the full zero map and a presence vector in which only the demanded sub-block's bit is set.

The record stays on the output until the consumer takes it. While it waits, the input stream is stalled.

Top module: `zdet_stream_top`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rec_valid` is 0 and `in_ready` is 1.
- R2: An element is flagged zero (bit value 1) only when every one of its bits is zero. Element width is 8 bits when `GRAN` is byte, and `WORD_W` bits when `GRAN` is word. Any element containing a set bit gives a 0 flag.
- R3: The zero map covers all `BEATS` beats of the block. The flag for element j (bits `j*ELEM_W` upward) of beat k (k = 0 for the start beat) sits at bit `k*EPB + j` of `rec_zero`, where `EPB = BEAT_W/ELEM_W`.
- R4: `rec_ind` has `BEATS/SUB_BEATS` bits. Exactly one bit is set: the bit whose index equals `in_sub` as sampled on the start beat. All others are 0.
- R5: `rec_tag` equals `in_tag` as sampled on the start beat. Values on `in_tag` and `in_sub` during later beats have no effect.
- R6: `rec_valid` rises in the cycle right after the handshake that delivers beat `BEATS-1`. It never rises for a block that has fewer accepted beats.
- R7: While `rec_valid` is 1 and `rec_ready` is 0, the record fields stay unchanged. The handshake with `rec_ready` clears `rec_valid` on the next cycle.
- R8: `in_ready` is 0 whenever a record is pending. A beat offered then is not consumed.
- R9: A beat with `in_sof` set in the middle of a block discards the partial block. That beat becomes beat 0 of a new block.
- R10: A beat accepted without `in_sof` while no block is in progress is dropped.
- R11: Idle cycles between the beats of one block do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken |
| in_sof | input | 1 | Beat is the first of an entry block |
| in_data | input | BEAT_W | Beat payload |
| in_tag | input | TAG_W | Entry tag, sampled on the start beat |
| in_sub | input | $clog2(BEATS/SUB_BEATS) | Demanded sub-block index, sampled on the start beat |
| rec_valid | output | 1 | Insertion record present |
| rec_ready | input | 1 | Consumer takes the record |
| rec_tag | output | TAG_W | Record tag |
| rec_zero | output | BEATS*BEAT_W/ELEM_W | Zero map, one bit per element |
| rec_ind | output | BEATS/SUB_BEATS | Presence vector, one-hot at the demanded sub-block |

## Verification
Two instances, one at byte granularity and one at word granularity, receive the same stimulus. This shows where the two maps must disagree: beats with a single set byte inside each word clear the word flags but leave most byte flags set. Fully zero and fully set blocks pin the map's extremes. Random beats mixing zero bytes, zero words and dense data test bit placement across beats.

Directed runs cover the stalled cases: a start beat offered while a record is pending, and restarted or headless streams. A wrong count, a stray capture or an early record would each surface as a record that should not exist.

// File: rtl/zdet_pkg.sv
package zdet_pkg;

    typedef enum logic {
        GRAN_BYTE = 1'b0,
        GRAN_WORD = 1'b1
    } gran_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_FILL = 1'b1
    } phase_e;

    localparam int BYTE_BITS = 8;

    function automatic int elem_width(gran_e g, int word_w);
        return (g == GRAN_BYTE) ? BYTE_BITS : word_w;
    endfunction

    function automatic int elems_per_beat(int beat_w, gran_e g, int word_w);
        return beat_w / elem_width(g, word_w);
    endfunction

endpackage

// File: rtl/zdet_elem_flags.sv
module zdet_elem_flags #(
    parameter int BEAT_W = 64,
    parameter int ELEM_W = 8,
    parameter int EPB    = BEAT_W / ELEM_W
) (
    input  logic [BEAT_W-1:0] beat,
    output logic [EPB-1:0]    is_zero
);

    for (genvar e = 0; e < EPB; e++) begin : g_elem
        assign is_zero[e] = (beat[e*ELEM_W +: ELEM_W] == '0);
    end

endmodule

// File: rtl/zdet_accum.sv
module zdet_accum #(
    parameter int BEATS     = 8,
    parameter int EPB       = 8,
    parameter int TAG_W     = 20,
    parameter int SUB_IDX_W = 2,
    parameter int ZV_W      = BEATS * EPB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 beat_fire,
    input  logic                 beat_sof,
    input  logic [EPB-1:0]       beat_flags,
    input  logic [TAG_W-1:0]     beat_tag,
    input  logic [SUB_IDX_W-1:0] beat_sub,
    output logic                 blk_done,
    output logic [ZV_W-1:0]      zv_next,
    output logic [TAG_W-1:0]     blk_tag,
    output logic [SUB_IDX_W-1:0] blk_sub
);
    import zdet_pkg::*;

    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    phase_e                 phase_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [ZV_W-1:0]        zv_q;
    logic [TAG_W-1:0]       tag_q;
    logic [SUB_IDX_W-1:0]   sub_q;

    logic start_beat;
    logic cont_beat;

    // New flags enter at the top; after BEATS shifts beat 0 sits lowest.
    assign zv_next    = {beat_flags, zv_q[ZV_W-1:EPB]};
    assign start_beat = beat_fire && beat_sof;
    assign cont_beat  = beat_fire && !beat_sof && (phase_q == PH_FILL);
    assign blk_done   = cont_beat && (cnt_q == LAST_BEAT);
    assign blk_tag    = tag_q;
    assign blk_sub    = sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            zv_q    <= '0;
            tag_q   <= '0;
            sub_q   <= '0;
        end else if (start_beat) begin
            phase_q <= PH_FILL;
            cnt_q   <= CNT_W'(1);
            zv_q    <= zv_next;
            tag_q   <= beat_tag;
            sub_q   <= beat_sub;
        end else if (cont_beat) begin
            zv_q  <= zv_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BEAT) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end
        end
    end

endmodule

// File: rtl/zdet_record.sv
module zdet_record #(
    parameter int ZV_W      = 64,
    parameter int TAG_W     = 20,
    parameter int N_SUB     = 4,
    parameter int SUB_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [ZV_W-1:0]      ld_zero,
    input  logic [TAG_W-1:0]     ld_tag,
    input  logic [SUB_IDX_W-1:0] ld_sub,
    input  logic                 rec_ready,
    output logic                 rec_valid,
    output logic [TAG_W-1:0]     rec_tag,
    output logic [ZV_W-1:0]      rec_zero,
    output logic [N_SUB-1:0]     rec_ind
);

    logic [N_SUB-1:0] ind_next;

    for (genvar s = 0; s < N_SUB; s++) begin : g_ind
        assign ind_next[s] = (ld_sub == SUB_IDX_W'(s));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_tag   <= '0;
            rec_zero  <= '0;
            rec_ind   <= '0;
        end else if (load) begin
            rec_valid <= 1'b1;
            rec_tag   <= ld_tag;
            rec_zero  <= ld_zero;
            rec_ind   <= ind_next;
        end else if (rec_valid && rec_ready) begin
            rec_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/zdet_stream_top.sv
module zdet_stream_top #(
    parameter int              BEAT_W    = 64,
    parameter int              BEATS     = 8,
    parameter int              SUB_BEATS = 2,
    parameter int              WORD_W    = 32,
    parameter int              TAG_W     = 20,
    parameter zdet_pkg::gran_e GRAN      = zdet_pkg::GRAN_BYTE,
    localparam int ELEM_W    = zdet_pkg::elem_width(GRAN, WORD_W),
    localparam int EPB       = zdet_pkg::elems_per_beat(BEAT_W, GRAN, WORD_W),
    localparam int ZV_W      = BEATS * EPB,
    localparam int N_SUB     = BEATS / SUB_BEATS,
    localparam int SUB_IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sof,
    input  logic [BEAT_W-1:0]    in_data,
    input  logic [TAG_W-1:0]     in_tag,
    input  logic [SUB_IDX_W-1:0] in_sub,
    output logic                 rec_valid,
    input  logic                 rec_ready,
    output logic [TAG_W-1:0]     rec_tag,
    output logic [ZV_W-1:0]      rec_zero,
    output logic [N_SUB-1:0]     rec_ind
);

    logic                 fire;
    logic [EPB-1:0]       flags;
    logic                 done;
    logic [ZV_W-1:0]      zv_next;
    logic [TAG_W-1:0]     blk_tag;
    logic [SUB_IDX_W-1:0] blk_sub;

    assign in_ready = !rec_valid;
    assign fire     = in_valid && in_ready;

    zdet_elem_flags #(
        .BEAT_W (BEAT_W),
        .ELEM_W (ELEM_W),
        .EPB    (EPB)
    ) u_flags (
        .beat    (in_data),
        .is_zero (flags)
    );

    zdet_accum #(
        .BEATS     (BEATS),
        .EPB       (EPB),
        .TAG_W     (TAG_W),
        .SUB_IDX_W (SUB_IDX_W),
        .ZV_W      (ZV_W)
    ) u_accum (
        .clk        (clk),
        .rst        (rst),
        .beat_fire  (fire),
        .beat_sof   (in_sof),
        .beat_flags (flags),
        .beat_tag   (in_tag),
        .beat_sub   (in_sub),
        .blk_done   (done),
        .zv_next    (zv_next),
        .blk_tag    (blk_tag),
        .blk_sub    (blk_sub)
    );

    zdet_record #(
        .ZV_W      (ZV_W),
        .TAG_W     (TAG_W),
        .N_SUB     (N_SUB),
        .SUB_IDX_W (SUB_IDX_W)
    ) u_record (
        .clk       (clk),
        .rst       (rst),
        .load      (done),
        .ld_zero   (zv_next),
        .ld_tag    (blk_tag),
        .ld_sub    (blk_sub),
        .rec_ready (rec_ready),
        .rec_valid (rec_valid),
        .rec_tag   (rec_tag),
        .rec_zero  (rec_zero),
        .rec_ind   (rec_ind)
    );

endmodule

// File: rtl/zdet_stream_chk.sv
module zdet_stream_chk #(
    parameter int BEATS = 8,
    parameter int ZV_W  = 64,
    parameter int TAG_W = 20,
    parameter int N_SUB = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_sof,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [TAG_W-1:0] rec_tag,
    input logic [ZV_W-1:0]  rec_zero,
    input logic [N_SUB-1:0] rec_ind
);

    localparam int SEEN_W = $clog2(BEATS + 1);

    // Beats seen in the current block, counted independently of the design.
    logic [SEEN_W-1:0] seen;
    logic              fire;
    assign fire = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (fire && in_sof) begin
            seen <= SEEN_W'(1);
        end else if (fire && seen != '0 && seen < SEEN_W'(BEATS)) begin
            seen <= seen + 1'b1;
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_zero)
                                    && $stable(rec_tag) && $stable(rec_ind));

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rec_valid) |-> $past(rec_ready));

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $countones(rec_ind) == 1);

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !in_ready);

    p_full_block_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> seen == SEEN_W'(BEATS));

    p_after_beat_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> $past(in_valid && in_ready && !in_sof));

endmodule

bind zdet_stream_top zdet_stream_chk #(
    .BEATS (BEATS),
    .ZV_W  (ZV_W),
    .TAG_W (TAG_W),
    .N_SUB (N_SUB)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sof    (in_sof),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_tag   (rec_tag),
    .rec_zero  (rec_zero),
    .rec_ind   (rec_ind)
);

// File: tb/sim_zdet_stream_top.sv
`timescale 1ns/1ps
module sim_zdet_stream_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [63:0] in_data = '0;
    logic [19:0] in_tag = '0;
    logic [1:0]  in_sub = '0;
    logic        rec_ready = 1'b0;

    logic        rdy0, rv0, rdy1, rv1;
    logic [19:0] tag0, tag1;
    logic [63:0] zero0;
    logic [15:0] zero1;
    logic [3:0]  ind0, ind1;

    int nchk = 0;
    int nfail = 0;

    logic [63:0] cur [8];

    always #4 clk = ~clk;

    zdet_stream_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy0),
        .in_sof(in_sof), .in_data(in_data), .in_tag(in_tag), .in_sub(in_sub),
        .rec_valid(rv0), .rec_ready(rec_ready), .rec_tag(tag0),
        .rec_zero(zero0), .rec_ind(ind0)
    );

    zdet_stream_top #(.GRAN(zdet_pkg::GRAN_WORD)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy1),
        .in_sof(in_sof), .in_data(in_data), .in_tag(in_tag), .in_sub(in_sub),
        .rec_valid(rv1), .rec_ready(rec_ready), .rec_tag(tag1),
        .rec_zero(zero1), .rec_ind(ind1)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_zero(input int ew);
        logic [63:0] v = '0;
        logic [63:0] mask = (64'd1 << ew) - 64'd1;
        int epb = 64 / ew;
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < epb; j++)
                v[k*epb + j] = (((cur[k] >> (j*ew)) & mask) == 64'd0);
        return v;
    endfunction

    task automatic send_beat(input logic [63:0] d, input bit sof,
                             input logic [19:0] t, input logic [1:0] s);
        while (!(rdy0 && rdy1)) @(negedge clk);
        in_valid = 1'b1;
        in_sof   = sof;
        in_data  = d;
        in_tag   = t;
        in_sub   = s;
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    // R5/R11: later beats carry junk tag/sub; optional idle gaps
    task automatic send_block(input logic [19:0] t, input logic [1:0] s,
                              input bit gaps);
        for (int k = 0; k < 8; k++) begin
            if (gaps && k > 0 && ($urandom % 3) == 0) @(negedge clk);
            if (k == 0) send_beat(cur[k], 1'b1, t, s);
            else        send_beat(cur[k], 1'b0, 20'($urandom), 2'($urandom));
        end
    endtask

    task automatic check_rec(input logic [19:0] t, input logic [1:0] s,
                             input int hold);
        logic [63:0] e0 = exp_zero(8);
        logic [63:0] e1 = exp_zero(32);
        logic [3:0]  ei = 4'b0001 << s;
        chk(rv0 && rv1, "R6", {62'd0, rv1, rv0}, 64'd3);
        chk(zero0 == e0, "R3", zero0, e0);
        chk(zero1 == e1[15:0], "R2", {48'd0, zero1}, e1);
        chk(tag0 == t && tag1 == t, "R5", {24'd0, tag1, tag0[19:0]}, {24'd0, t, t});
        chk(ind0 == ei && ind1 == ei, "R4", {56'd0, ind1, ind0}, {56'd0, ei, ei});
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rv0 && zero0 == e0 && tag0 == t && zero1 == e1[15:0], "R7",
                zero0, e0);
            chk(!rdy0 && !rdy1, "R8", {62'd0, rdy1, rdy0}, 64'd0);
        end
        rec_ready = 1'b1;
        @(negedge clk);
        rec_ready = 1'b0;
        chk(!rv0 && !rv1, "R7", {62'd0, rv1, rv0}, 64'd0);
    endtask

    task automatic fill_random();
        for (int k = 0; k < 8; k++) begin
            case ($urandom % 4)
                0: cur[k] = '0;
                1: begin
                    cur[k] = {$urandom, $urandom};
                    for (int b = 0; b < 8; b++)
                        if ($urandom % 2) cur[k][b*8 +: 8] = 8'h00;
                end
                2: cur[k] = ($urandom % 2) ? {$urandom | 32'h1, 32'h0}
                                           : {32'h0, $urandom | 32'h1};
                default: cur[k] = {$urandom, $urandom} | 64'h1;
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!rv0 && !rv1 && rdy0 && rdy1, "R1", {60'd0, rdy1, rdy0, rv1, rv0}, 64'hC);
        rst = 1'b0;
        @(negedge clk);
        chk(!rv0 && !rv1 && rdy0 && rdy1, "R1", {60'd0, rdy1, rdy0, rv1, rv0}, 64'hC);

        // R10: headless beats while idle are dropped
        for (int k = 0; k < 8; k++) send_beat(64'h0, 1'b0, 20'h1, 2'd1);
        @(negedge clk);
        chk(!rv0 && !rv1, "R10", {62'd0, rv1, rv0}, 64'd0);

        // all-zero block
        for (int k = 0; k < 8; k++) cur[k] = '0;
        send_block(20'hABCDE, 2'd0, 1'b0);
        check_rec(20'hABCDE, 2'd0, 0);

        // all-ones block
        for (int k = 0; k < 8; k++) cur[k] = '1;
        send_block(20'h12345, 2'd3, 1'b0);
        check_rec(20'h12345, 2'd3, 2);

        // R2: one set byte per word, word flags clear, byte flags mostly set
        for (int k = 0; k < 8; k++) cur[k] = 64'h0001_0000_0000_0100 << (k % 2);
        send_block(20'h0F0F0, 2'd2, 1'b1);
        check_rec(20'h0F0F0, 2'd2, 1);

        // R9: restart mid-block
        for (int k = 0; k < 3; k++) send_beat(64'hFFFF, k == 0, 20'h77777, 2'd3);
        for (int k = 0; k < 8; k++) cur[k] = (k % 2) ? 64'h0 : 64'hFF00_0000_0000_00FF;
        send_block(20'h55555, 2'd1, 1'b0);
        check_rec(20'h55555, 2'd1, 0);

        // R8: start beat offered while pending must not be taken
        fill_random();
        send_block(20'h0BEEF, 2'd2, 1'b0);
        in_valid = 1'b1; in_sof = 1'b1; in_data = '0;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        check_rec(20'h0BEEF, 2'd2, 1);
        for (int k = 0; k < 7; k++) send_beat(64'h0, 1'b0, 20'h0, 2'd0);
        @(negedge clk);
        chk(!rv0 && !rv1, "R8", {62'd0, rv1, rv0}, 64'd0);

        // random blocks with gaps and backpressure (R11)
        for (int n = 0; n < 60; n++) begin
            logic [19:0] t = 20'($urandom);
            logic [1:0]  s = 2'($urandom);
            fill_random();
            send_block(t, s, 1'b1);
            check_rec(t, s, int'($urandom % 3));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule